// File: doc/BRIEF.md
# Watchdog Timer with Stop-Mode Clock Policy

This block is a free-running watchdog. A counter advances on ticks of one of three clock sources and, unless software services it in time, reaches a limit and raises a one-cycle reset request. Software services it by writing two key bytes in a fixed order. A wrong key, or the right keys in the wrong order, raises the reset at once. A 3-bit rate field sets the timeout period and disables the watchdog when it is zero.

Each clock source is presented as a one-cycle tick strobe in the `clk` domain: `lp_tick` for the always-on low-power clock, `rc_tick` for the internal RC clock and `osc_tick` for the external oscillator clock. The stop-mode request is a level input. A synchroniser in the low-power domain turns it into `stop_ack`. While `stop_ack` is high, a policy decode of the source select, the stop type, the oscillator configuration and status, and a low-power stop-disable bit decides whether the counter keeps running or stays frozen.

State machines. The service FSM (`wdg_svc`) has the states SV_IDLE and SV_KEYED. In SV_IDLE, a write of 0x55 goes to SV_KEYED and any other write flags an error and stays in SV_IDLE. In SV_KEYED, a write of 0xAA clears the counter and returns to SV_IDLE, and any other write flags an error and returns to SV_IDLE. The stop synchroniser (`wdg_stop_sync`) has the states ST_RUN, ST_ENTER, ST_STOP, ST_EXIT, ST_HOLD1 and ST_HOLD2. Every transition happens only on an `lp_tick`. ST_RUN goes to ST_ENTER when the request is high. ST_ENTER always goes to ST_STOP. ST_STOP goes to ST_EXIT when the request is low. ST_EXIT goes to ST_HOLD1, ST_HOLD1 goes to ST_HOLD2, and ST_HOLD2 goes to ST_RUN. `stop_ack` is high in ST_STOP and ST_EXIT.

Top module: `wdg_top`

## Requirements
- R1: After reset, `stop_ack` and `wdog_rst` are 0 and the counter is 0.
- R2: With `rate` = r (1..7), `wdog_rst` rises in the cycle after the 2^(BASE+r)-th tick of the selected source counted from a cleared counter. The counter then restarts from 0.
- R3: With `rate` = 0, the counter is held at 0, `wdog_rst` never rises, and service writes are ignored.
- R4: `src_sel` = 2'b1x selects `lp_tick`, 2'b01 selects `osc_tick` and 2'b00 selects `rc_tick`. Ticks of the unselected sources do not advance the counter.
- R5: A write of 0x55 followed by a write of 0xAA clears the counter, so a full new period is needed before expiry.
- R6: A first write other than 0x55, or a second write other than 0xAA, makes `wdog_rst` high in the cycle after that write.
- R7: With the low-power source selected and `stop_ack` high, the counter runs when `lp_stop_dis` = 0 and is frozen when `lp_stop_dis` = 1.
- R8: With the oscillator source selected and `stop_ack` high, the counter runs only when `stop_pseudo`, `osc_keep_pstp`, `osc_en` and `osc_up` are all 1. With the RC source selected it is always frozen in stop.
- R9: `stop_ack` rises on the 2nd `lp_tick` after `stop_req` goes high and falls on the 2nd `lp_tick` after `stop_req` goes low. It does not change without an `lp_tick`.
- R10: After `stop_ack` falls, two `lp_tick`s pass before a new request is taken, so with `stop_req` held high `stop_ack` rises again on the 4th `lp_tick`.
- R11: `wdog_rst` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_tick | input | 1 | Low-power clock tick strobe |
| rc_tick | input | 1 | Internal RC clock tick strobe |
| osc_tick | input | 1 | Oscillator clock tick strobe |
| src_sel | input | 2 | Counting source select |
| lp_stop_dis | input | 1 | Freeze counter in stop when low-power source is used |
| stop_req | input | 1 | Stop-mode request level |
| stop_pseudo | input | 1 | 1 = pseudo stop, 0 = full stop |
| osc_keep_pstp | input | 1 | Oscillator kept running in pseudo stop |
| osc_en | input | 1 | Oscillator enable |
| osc_up | input | 1 | Oscillator stable status |
| rate | input | 3 | Timeout tap select, 0 disables |
| svc_wr | input | 1 | Service write strobe |
| svc_data | input | 8 | Service write byte |
| stop_ack | output | 1 | Synchronised stop status |
| wdog_rst | output | 1 | Watchdog reset pulse |

## Verification
If the stop synchroniser holds a wrong state, `stop_ack` moves on the wrong `lp_tick`. This shows up within one or two ticks of a request edge or of the end of the hold-off. A wrong service state shows up on the next write as either a missing or a spurious `wdog_rst`. A wrong counter value or run decision only shows up when expiry comes early, comes late or never comes. For that reason the bench counts ticks up to the exact expiry cycle, and for each run/freeze case it checks whether a timeout happens while in stop.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [0:0] {
        SV_IDLE,
        SV_KEYED
    } svc_st_t;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_ENTER,
        ST_STOP,
        ST_EXIT,
        ST_HOLD1,
        ST_HOLD2
    } stop_st_t;
endpackage

// File: rtl/wdg_svc.sv
module wdg_svc
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       wr,
    input  logic [7:0] data,
    output logic       ok,
    output logic       bad
);
    svc_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SV_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        ok   = 1'b0;
        bad  = 1'b0;
        if (!en) begin
            st_d = SV_IDLE;
        end else if (wr) begin
            unique case (st_q)
                SV_IDLE: begin
                    if (data == KEY_FIRST) st_d = SV_KEYED;
                    else                   bad  = 1'b1;
                end
                SV_KEYED: begin
                    st_d = SV_IDLE;
                    if (data == KEY_SECOND) ok  = 1'b1;
                    else                    bad = 1'b1;
                end
                default: st_d = SV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wdg_stop_sync.sv
module wdg_stop_sync
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lp_tick,
    input  logic req,
    output logic ack
);
    stop_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (lp_tick) begin
            unique case (st_q)
                ST_RUN:   if (req)  st_d = ST_ENTER;
                ST_ENTER:           st_d = ST_STOP;
                ST_STOP:  if (!req) st_d = ST_EXIT;
                ST_EXIT:            st_d = ST_HOLD1;
                ST_HOLD1:           st_d = ST_HOLD2;
                ST_HOLD2:           st_d = ST_RUN;
                default:            st_d = ST_RUN;
            endcase
        end
    end

    always_comb begin
        ack = (st_q == ST_STOP) || (st_q == ST_EXIT);
    end
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
    parameter int BASE = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic       clr,
    input  logic [2:0] rate,
    output logic       expire
);
    localparam int W = BASE + 7;

    logic [W-1:0] cnt_q;
    logic [W-1:0] limit;
    logic         active;

    always_comb begin
        limit  = ({{(W-1){1'b0}}, 1'b1} << (BASE + int'(rate))) - 1'b1;
        active = (rate != 3'd0);
        expire = active && run && tick && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (clr || !active)      cnt_q <= '0;
        else if (expire)              cnt_q <= '0;
        else if (run && tick)         cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdg_top.sv
module wdg_top #(
    parameter int BASE = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_tick,
    input  logic       rc_tick,
    input  logic       osc_tick,
    input  logic [1:0] src_sel,
    input  logic       lp_stop_dis,
    input  logic       stop_req,
    input  logic       stop_pseudo,
    input  logic       osc_keep_pstp,
    input  logic       osc_en,
    input  logic       osc_up,
    input  logic [2:0] rate,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       stop_ack,
    output logic       wdog_rst
);
    logic sel_tick, run_in_stop, cnt_run;
    logic svc_ok, svc_bad, expire;

    always_comb begin
        if (src_sel[1]) begin
            sel_tick    = lp_tick;
            run_in_stop = !lp_stop_dis;
        end else if (src_sel[0]) begin
            sel_tick    = osc_tick;
            run_in_stop = stop_pseudo && osc_keep_pstp && osc_en && osc_up;
        end else begin
            sel_tick    = rc_tick;
            run_in_stop = 1'b0;
        end
        cnt_run = !stop_ack || run_in_stop;
    end

    wdg_stop_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lp_tick (lp_tick),
        .req     (stop_req),
        .ack     (stop_ack)
    );

    wdg_svc u_svc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rate != 3'd0),
        .wr    (svc_wr),
        .data  (svc_data),
        .ok    (svc_ok),
        .bad   (svc_bad)
    );

    wdg_count #(.BASE(BASE)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sel_tick),
        .run    (cnt_run),
        .clr    (svc_ok || svc_bad),
        .rate   (rate),
        .expire (expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wdog_rst <= 1'b0;
        else        wdog_rst <= expire || svc_bad;
    end
endmodule

// File: rtl/wdg_top_chk.sv
module wdg_top_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lp_tick,
    input logic [1:0] src_sel,
    input logic       lp_stop_dis,
    input logic [2:0] rate,
    input logic       svc_wr,
    input logic       stop_ack,
    input logic       wdog_rst
);
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_rst && !$past(svc_wr)) |=> !wdog_rst);

    p_ack_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_ack) |-> $past(lp_tick));

    p_ack_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_ack) |-> $past(lp_tick));

    p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == 3'd0 && $past(rate) == 3'd0) |-> !wdog_rst);

    p_lp_static_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ack && $past(stop_ack) && src_sel[1] && $past(src_sel[1])
         && lp_stop_dis && $past(lp_stop_dis) && !$past(svc_wr)) |-> !wdog_rst);
endmodule

bind wdg_top wdg_top_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lp_tick     (lp_tick),
    .src_sel     (src_sel),
    .lp_stop_dis (lp_stop_dis),
    .rate        (rate),
    .svc_wr      (svc_wr),
    .stop_ack    (stop_ack),
    .wdog_rst    (wdog_rst)
);

// File: tb/wdg_top_tb.sv
module wdg_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lp_tick = 1'b0, rc_tick = 1'b0, osc_tick = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       lp_stop_dis = 1'b0, stop_req = 1'b0, stop_pseudo = 1'b0;
    logic       osc_keep_pstp = 1'b0, osc_en = 1'b0, osc_up = 1'b0;
    logic [2:0] rate = 3'd0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       stop_ack, wdog_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5ns clk = ~clk;

    wdg_top #(.BASE(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick), .rc_tick(rc_tick),
        .osc_tick(osc_tick), .src_sel(src_sel), .lp_stop_dis(lp_stop_dis),
        .stop_req(stop_req), .stop_pseudo(stop_pseudo),
        .osc_keep_pstp(osc_keep_pstp), .osc_en(osc_en), .osc_up(osc_up),
        .rate(rate), .svc_wr(svc_wr), .svc_data(svc_data),
        .stop_ack(stop_ack), .wdog_rst(wdog_rst)
    );

    // {src_sel[1:0], lp_stop_dis, stop_pseudo, osc_keep_pstp, osc_en, osc_up, expect_run}
    localparam logic [7:0] VEC [8] = '{
        8'b10_0_0000_1,
        8'b10_1_1111_0,
        8'b01_0_1111_1,
        8'b01_0_0111_0,
        8'b01_0_1011_0,
        8'b01_0_1101_0,
        8'b01_0_1110_0,
        8'b00_0_1111_0
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {lp_tick, rc_tick, osc_tick} = 3'b000;
        src_sel = 2'b00; lp_stop_dis = 1'b0; stop_req = 1'b0;
        stop_pseudo = 1'b0; osc_keep_pstp = 1'b0; osc_en = 1'b0; osc_up = 1'b0;
        rate = 3'd0; svc_wr = 1'b0; svc_data = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // mode = {lp, rc, osc}; returns at the negedge after the ticking edge
    task automatic pulse(input logic [2:0] mode);
        @(negedge clk);
        {lp_tick, rc_tick, osc_tick} = mode;
        @(negedge clk);
        {lp_tick, rc_tick, osc_tick} = 3'b000;
    endtask

    task automatic write(input logic [7:0] d);
        @(negedge clk);
        svc_wr = 1'b1; svc_data = d;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    // n-1 ticks with no reset, the n-th tick gives the reset, then it drops
    task automatic expect_period(input logic [2:0] mode, input int n, input string tag);
        int early = 0;
        for (int i = 1; i < n; i++) begin
            pulse(mode);
            if (wdog_rst) early++;
        end
        check(early == 0, tag, early, 0);
        pulse(mode);
        check(wdog_rst == 1'b1, tag, wdog_rst, 1);
        @(negedge clk);
        check(wdog_rst == 1'b0, "R11 pulse width", wdog_rst, 0);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seen;
        do_reset();
        @(negedge clk);
        check(stop_ack == 1'b0, "R1 stop_ack", stop_ack, 0);
        check(wdog_rst == 1'b0, "R1 wdog_rst", wdog_rst, 0);

        // R7 / R8: vector walk of run/freeze policy in stop
        foreach (VEC[k]) begin
            do_reset();
            {src_sel, lp_stop_dis, stop_pseudo, osc_keep_pstp, osc_en, osc_up} = VEC[k][7:1];
            rate = 3'd1;
            stop_req = 1'b1;
            pulse(3'b100);
            pulse(3'b100);
            check(stop_ack == 1'b1, "R9 ack in vector", stop_ack, 1);
            seen = 0;
            for (int i = 0; i < 20; i++) begin
                pulse(3'b111);
                if (wdog_rst) seen++;
            end
            check((seen != 0) == VEC[k][0], src_sel[1] ? "R7 lp policy" : "R8 osc/rc policy",
                  seen != 0, VEC[k][0]);
        end

        // R2 / R4: source select and taps
        do_reset();
        rate = 3'd1; src_sel = 2'b00;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            pulse(3'b101);
            if (wdog_rst) seen++;
        end
        check(seen == 0, "R4 unselected ticks", seen, 0);
        expect_period(3'b010, 8, "R4 rc rate1");
        do_reset();
        rate = 3'd2; src_sel = 2'b10;
        expect_period(3'b100, 16, "R2 lp rate2");
        do_reset();
        rate = 3'd3; src_sel = 2'b01;
        expect_period(3'b001, 32, "R2 osc rate3");
        expect_period(3'b001, 32, "R2 restart after expiry");

        // R5: correct service
        do_reset();
        rate = 3'd1; src_sel = 2'b00;
        repeat (6) pulse(3'b010);
        write(8'h55);
        check(wdog_rst == 1'b0, "R5 first key", wdog_rst, 0);
        write(8'hAA);
        check(wdog_rst == 1'b0, "R5 second key", wdog_rst, 0);
        expect_period(3'b010, 8, "R5 full period after service");

        // R6: bad keys
        write(8'h12);
        check(wdog_rst == 1'b1, "R6 bad first", wdog_rst, 1);
        @(negedge clk);
        check(wdog_rst == 1'b0, "R11 after bad", wdog_rst, 0);
        write(8'hAA);
        check(wdog_rst == 1'b1, "R6 wrong order", wdog_rst, 1);
        @(negedge clk);
        write(8'h55);
        check(wdog_rst == 1'b0, "R6 55 accepted", wdog_rst, 0);
        write(8'h55);
        check(wdog_rst == 1'b1, "R6 bad second", wdog_rst, 1);

        // R3: disabled
        do_reset();
        rate = 3'd0; src_sel = 2'b00;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            pulse(3'b111);
            if (wdog_rst) seen++;
        end
        write(8'h12);
        if (wdog_rst) seen++;
        check(seen == 0, "R3 disabled", seen, 0);
        rate = 3'd1;
        expect_period(3'b010, 8, "R3 counter held at zero");

        // R9 / R10: stop synchronisation latency and hold-off
        do_reset();
        stop_req = 1'b1;
        repeat (5) @(negedge clk);
        check(stop_ack == 1'b0, "R9 no tick no change", stop_ack, 0);
        pulse(3'b100);
        check(stop_ack == 1'b0, "R9 entry tick1", stop_ack, 0);
        pulse(3'b100);
        check(stop_ack == 1'b1, "R9 entry tick2", stop_ack, 1);
        stop_req = 1'b0;
        pulse(3'b100);
        check(stop_ack == 1'b1, "R9 exit tick1", stop_ack, 1);
        pulse(3'b100);
        check(stop_ack == 1'b0, "R9 exit tick2", stop_ack, 0);
        stop_req = 1'b1;
        pulse(3'b100); pulse(3'b100); pulse(3'b100);
        check(stop_ack == 1'b0, "R10 hold-off tick3", stop_ack, 0);
        pulse(3'b100);
        check(stop_ack == 1'b1, "R10 re-entry tick4", stop_ack, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule